// File: doc/BRIEF.md
# Static Memory Bus Cycle Sequencer

This block runs one read or one write at a time on an asynchronous static memory bus that has a single chip select. An internal requester holds `req_valid` high together with the address, write data, byte enables and direction. The block accepts the request when it is idle. It then drives the chip select, read strobe, write strobe(s) and byte selects through a setup phase, a pulse phase and a hold phase. The length of each phase comes from a programmable count. At the end it raises `req_ack` for one clock, and for a read it returns the captured data on `rsp_rdata` in that same clock.

The configuration inputs select several behaviours. They choose an 8-bit or 16-bit bus. They choose how byte lanes are signalled on a 16-bit bus: byte selects with a single write strobe, or one write strobe per byte. They choose whether a write is timed by the write strobe or by the chip select. They also choose how an external wait input, active low, stretches the pulse phase. In freeze mode the wait input stops the phase counter and the cycle resumes where it stopped. In ready mode the wait input is tested when the pulse count runs out. All configuration and timing values are latched when a request is accepted.

Top module: `sram_cycle_seq`

## Requirements
- R1: In reset and while idle, `mem_cs_n`, `mem_rd_n`, `mem_we_n`, every bit of `mem_wr_n` and every bit of `mem_bs_n` are 1, `mem_dq_oe` is 0 and `req_ack` is 0.
- R2: A request held on `req_valid` while idle is accepted at a rising edge. In a read, `mem_cs_n` is then low for setup+pulse+hold cycles and `mem_rd_n` is low for exactly the pulse cycles that follow the setup cycles. `req_ack` is high for the one cycle right after the last hold cycle. A setup or hold count of 0 skips that phase.
- R3: A pulse count of 0 is treated as a pulse of one cycle.
- R4: With `cfg_we_timed`=1, a write holds the chip select low for all three phases and the write strobe low only in the pulse. With `cfg_we_timed`=0, the roles swap: the write strobe is low for all three phases and `mem_cs_n` is low only in the pulse. During every write cycle `mem_dq_oe` is 1.
- R5: Read data is sampled from `mem_dq_i` on the last pulse cycle and appears on `rsp_rdata` in the acknowledge cycle. On an 8-bit bus the upper byte of `rsp_rdata` is 0.
- R6: On an 8-bit bus (`cfg_bus16`=0), the byte selects and per-byte strobes stay 1 and writes use `mem_we_n`. `mem_dq_o[7:0]` carries `req_wdata[7:0]` and `mem_dq_o[15:8]` is 0.
- R7: On a 16-bit bus in byte-select style (`cfg_byte_write`=0), `mem_bs_n` equals the inverse of the latched byte enables in every phase of both reads and writes. Writes use the single strobe `mem_we_n`.
- R8: On a 16-bit bus in byte-write style (`cfg_byte_write`=1), write strobe bit i of `mem_wr_n` follows the write-strobe timing only when byte enable i is 1, and `mem_we_n` stays 1. Reads keep `mem_bs_n` at 2'b11.
- R9: Wait modes 2'b00 (off) and 2'b01 (reserved) ignore `mem_wait_n`.
- R10: In wait mode 2'b10 (freeze), each pulse cycle in which the synchronised wait input is low adds one cycle to the pulse. No pulse cycles are lost.
- R11: In wait mode 2'b11 (ready), the pulse is extended while the synchronised wait input is low on the cycle where the pulse count has expired. A low wait input earlier in the pulse has no effect.
- R12: In wait modes 2'b10 and 2'b11, a hold count of 0 is raised to one hold cycle.
- R13: `mem_wait_n` goes through a two-stage synchroniser before use. A low level that reaches the sequencer during setup or hold has no effect.
- R14: Configuration and request inputs are latched at acceptance, so changes during a cycle do not alter it. `req_ack` lasts exactly one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request held until acknowledged |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit i for byte i |
| req_ack | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 16 | Read data, valid with req_ack |
| cfg_wait_mode | input | 2 | 00 off, 01 reserved (off), 10 freeze, 11 ready |
| cfg_bus16 | input | 1 | 1 = 16-bit bus, 0 = 8-bit bus |
| cfg_byte_write | input | 1 | 1 = per-byte write strobes, 0 = byte selects |
| cfg_we_timed | input | 1 | 1 = writes timed by write strobe, 0 = by chip select |
| cfg_rd_setup | input | 6 | Read setup cycles |
| cfg_rd_pulse | input | 6 | Read pulse cycles |
| cfg_rd_hold | input | 6 | Read hold cycles |
| cfg_wr_setup | input | 6 | Write setup cycles |
| cfg_wr_pulse | input | 6 | Write pulse cycles |
| cfg_wr_hold | input | 6 | Write hold cycles |
| mem_addr | output | ADDR_W | Latched bus address |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_rd_n | output | 1 | Read strobe, active low |
| mem_we_n | output | 1 | Single write strobe, active low |
| mem_wr_n | output | 2 | Per-byte write strobes, active low |
| mem_bs_n | output | 2 | Byte selects, active low |
| mem_dq_o | output | 16 | Write data to the bus |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_i | input | 16 | Read data from the bus |
| mem_wait_n | input | 1 | External wait, active low |

## Verification
The bench places the wait window at specific points, counting from the accept edge and allowing for the synchroniser delay. One window falls inside the pulse in freeze mode; a design that restarts the counter after a freeze would lengthen the pulse by too much, and one that keeps counting would not lengthen it at all. Other windows fall only in setup or hold, only early in a ready-mode pulse, or fall while the wait mode is off or reserved. In each of these cases a design that samples wait outside the intended point changes the strobe widths. Zero pulse and zero hold counts under an enabled wait mode check the minimum-length rules. The bench also changes the configuration after acceptance to catch a design that does not latch it. Each lane style and both write-timing modes are compared cycle by cycle, so a swapped chip-select and strobe role or a wrong byte-lane mask appears in the first cycle it occurs.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

    localparam int CNT_W  = 6;
    localparam int DATA_W = 16;
    localparam int LANES  = DATA_W / 8;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SETUP = 2'd1,
        PH_PULSE = 2'd2,
        PH_HOLD  = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        WM_OFF    = 2'd0,
        WM_RSVD   = 2'd1,
        WM_FREEZE = 2'd2,
        WM_READY  = 2'd3
    } wait_mode_e;

    typedef struct packed {
        logic [CNT_W-1:0] setup;
        logic [CNT_W-1:0] pulse;
        logic [CNT_W-1:0] hold;
    } timing_t;

    typedef struct packed {
        logic              is_write;
        logic              bus16;
        logic              byte_write;
        logic              we_ctrl;
        wait_mode_e        wmode;
        logic [LANES-1:0]  be;
        logic [DATA_W-1:0] wdata;
        timing_t           tm;
    } xfer_t;

    typedef struct packed {
        logic             cs_n;
        logic             rd_n;
        logic             we_n;
        logic [LANES-1:0] wr_n;
        logic [LANES-1:0] bs_n;
        logic             oe;
    } pins_t;

    function automatic logic wait_enabled(wait_mode_e m);
        return (m == WM_FREEZE) || (m == WM_READY);
    endfunction

    function automatic logic [CNT_W-1:0] pulse_len(logic [CNT_W-1:0] p);
        return (p == '0) ? CNT_W'(1) : p;
    endfunction

    function automatic logic [CNT_W-1:0] hold_len(logic [CNT_W-1:0] h, wait_mode_e m);
        return (wait_enabled(m) && h == '0) ? CNT_W'(1) : h;
    endfunction

endpackage

// File: rtl/sram_seq_sync.sv
module sram_seq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/sram_seq_phase.sv
module sram_seq_phase
    import sram_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  timing_t    start_tm,
    input  timing_t    cur_tm,
    input  wait_mode_e cur_wm,
    input  logic       wait_req,
    output phase_e     phase,
    output logic       pulse_done,
    output logic       cycle_done
);
    logic [CNT_W-1:0] cnt, cnt_n, hl;
    phase_e           ph_n;
    logic             freeze, extend;

    assign hl     = hold_len(cur_tm.hold, cur_wm);
    assign freeze = (cur_wm == WM_FREEZE) && wait_req;
    assign extend = (cur_wm == WM_READY)  && wait_req;

    always_comb begin
        ph_n       = phase;
        cnt_n      = cnt;
        pulse_done = 1'b0;
        cycle_done = 1'b0;
        case (phase)
            PH_IDLE: begin
                if (start) begin
                    if (start_tm.setup != '0) begin
                        ph_n  = PH_SETUP;
                        cnt_n = start_tm.setup - 1'b1;
                    end else begin
                        ph_n  = PH_PULSE;
                        cnt_n = pulse_len(start_tm.pulse) - 1'b1;
                    end
                end
            end
            PH_SETUP: begin
                if (cnt != '0) cnt_n = cnt - 1'b1;
                else begin
                    ph_n  = PH_PULSE;
                    cnt_n = pulse_len(cur_tm.pulse) - 1'b1;
                end
            end
            PH_PULSE: begin
                if (freeze) begin
                    cnt_n = cnt;
                end else if (cnt != '0) begin
                    cnt_n = cnt - 1'b1;
                end else if (!extend) begin
                    pulse_done = 1'b1;
                    if (hl != '0) begin
                        ph_n  = PH_HOLD;
                        cnt_n = hl - 1'b1;
                    end else begin
                        ph_n       = PH_IDLE;
                        cycle_done = 1'b1;
                    end
                end
            end
            default: begin
                if (cnt != '0) cnt_n = cnt - 1'b1;
                else begin
                    ph_n       = PH_IDLE;
                    cycle_done = 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else begin
            phase <= ph_n;
            cnt   <= cnt_n;
        end
    end
endmodule

// File: rtl/sram_seq_pins.sv
module sram_seq_pins
    import sram_seq_pkg::*;
(
    input  phase_e phase,
    input  xfer_t  xfer,
    output pins_t  pins
);
    logic active, in_pulse, strobe_on, cs_on, lane_sel, per_byte;

    assign active   = (phase != PH_IDLE);
    assign in_pulse = (phase == PH_PULSE);
    assign lane_sel = xfer.bus16 && !xfer.byte_write;
    assign per_byte = xfer.bus16 && xfer.byte_write;

    always_comb begin
        strobe_on = xfer.we_ctrl ? in_pulse : 1'b1;
        cs_on     = xfer.we_ctrl ? 1'b1 : in_pulse;
        pins.cs_n = 1'b1;
        pins.rd_n = 1'b1;
        pins.we_n = 1'b1;
        pins.wr_n = '1;
        pins.bs_n = '1;
        pins.oe   = 1'b0;
        if (active) begin
            pins.bs_n = lane_sel ? ~xfer.be : '1;
            if (!xfer.is_write) begin
                pins.cs_n = 1'b0;
                pins.rd_n = !in_pulse;
            end else begin
                pins.oe   = 1'b1;
                pins.cs_n = !cs_on;
                if (per_byte) pins.wr_n = strobe_on ? ~xfer.be : '1;
                else          pins.we_n = !strobe_on;
            end
        end
    end
endmodule

// File: rtl/sram_cycle_seq.sv
module sram_cycle_seq
    import sram_seq_pkg::*;
#(
    parameter int ADDR_W      = 24,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_be,
    output logic              req_ack,
    output logic [DATA_W-1:0] rsp_rdata,
    input  logic [1:0]        cfg_wait_mode,
    input  logic              cfg_bus16,
    input  logic              cfg_byte_write,
    input  logic              cfg_we_timed,
    input  logic [CNT_W-1:0]  cfg_rd_setup,
    input  logic [CNT_W-1:0]  cfg_rd_pulse,
    input  logic [CNT_W-1:0]  cfg_rd_hold,
    input  logic [CNT_W-1:0]  cfg_wr_setup,
    input  logic [CNT_W-1:0]  cfg_wr_pulse,
    input  logic [CNT_W-1:0]  cfg_wr_hold,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_rd_n,
    output logic              mem_we_n,
    output logic [LANES-1:0]  mem_wr_n,
    output logic [LANES-1:0]  mem_bs_n,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_i,
    input  logic              mem_wait_n
);
    xfer_t             xfer_q, xfer_new;
    phase_e            phase;
    pins_t             pins;
    logic              accept, pulse_done, cycle_done, wait_s;
    logic [DATA_W-1:0] rd_lanes;

    always_comb begin
        xfer_new.is_write   = req_write;
        xfer_new.bus16      = cfg_bus16;
        xfer_new.byte_write = cfg_byte_write;
        xfer_new.we_ctrl    = cfg_we_timed;
        xfer_new.wmode      = wait_mode_e'(cfg_wait_mode);
        xfer_new.be         = req_be;
        xfer_new.wdata      = req_wdata;
        xfer_new.tm.setup   = req_write ? cfg_wr_setup : cfg_rd_setup;
        xfer_new.tm.pulse   = req_write ? cfg_wr_pulse : cfg_rd_pulse;
        xfer_new.tm.hold    = req_write ? cfg_wr_hold  : cfg_rd_hold;
    end

    assign accept = req_valid && (phase == PH_IDLE) && !req_ack;

    sram_seq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (mem_wait_n),
        .dout (wait_s)
    );

    sram_seq_phase u_phase (
        .clk        (clk),
        .rst        (rst),
        .start      (accept),
        .start_tm   (xfer_new.tm),
        .cur_tm     (xfer_q.tm),
        .cur_wm     (xfer_q.wmode),
        .wait_req   (!wait_s),
        .phase      (phase),
        .pulse_done (pulse_done),
        .cycle_done (cycle_done)
    );

    sram_seq_pins u_pins (
        .phase (phase),
        .xfer  (xfer_q),
        .pins  (pins)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        if (g == 0) begin : g_base
            assign mem_dq_o[7:0] = xfer_q.wdata[7:0];
            assign rd_lanes[7:0] = mem_dq_i[7:0];
        end else begin : g_wide
            assign mem_dq_o[g*8 +: 8] = xfer_q.bus16 ? xfer_q.wdata[g*8 +: 8] : 8'h00;
            assign rd_lanes[g*8 +: 8] = xfer_q.bus16 ? mem_dq_i[g*8 +: 8]    : 8'h00;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            xfer_q    <= '0;
            mem_addr  <= '0;
            req_ack   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            if (accept) begin
                xfer_q   <= xfer_new;
                mem_addr <= req_addr;
            end
            req_ack <= cycle_done;
            if (pulse_done && !xfer_q.is_write) rsp_rdata <= rd_lanes;
        end
    end

    assign mem_cs_n  = pins.cs_n;
    assign mem_rd_n  = pins.rd_n;
    assign mem_we_n  = pins.we_n;
    assign mem_wr_n  = pins.wr_n;
    assign mem_bs_n  = pins.bs_n;
    assign mem_dq_oe = pins.oe;
endmodule

// File: rtl/sram_cycle_seq_chk.sv
module sram_cycle_seq_chk
    import sram_seq_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             ack,
    input logic             cs_n,
    input logic             rd_n,
    input logic             we_n,
    input logic [LANES-1:0] wr_n,
    input logic [LANES-1:0] bs_n,
    input logic             dq_oe,
    input phase_e           phase,
    input xfer_t            xfer
);
    // R14
    ack_single_chk: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack);

    // R2
    ack_bus_idle_chk: assert property (@(posedge clk) disable iff (rst)
        ack |-> (cs_n && rd_n && we_n && wr_n == '1 && !dq_oe));

    // R2
    read_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_n |-> (!cs_n && !dq_oe && we_n && wr_n == '1));

    // R12
    min_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_PULSE && wait_enabled(xfer.wmode)) |=>
        (phase == PH_PULSE || phase == PH_HOLD));

    // R8
    bw_read_lanes_chk: assert property (@(posedge clk) disable iff (rst)
        (!rd_n && xfer.bus16 && xfer.byte_write) |-> (bs_n == '1));

    // R6
    narrow_lanes_chk: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_IDLE && !xfer.bus16) |-> (bs_n == '1 && wr_n == '1));
endmodule

bind sram_cycle_seq sram_cycle_seq_chk u_chk (
    .clk   (clk),
    .rst   (rst),
    .ack   (req_ack),
    .cs_n  (mem_cs_n),
    .rd_n  (mem_rd_n),
    .we_n  (mem_we_n),
    .wr_n  (mem_wr_n),
    .bs_n  (mem_bs_n),
    .dq_oe (mem_dq_oe),
    .phase (phase),
    .xfer  (xfer_q)
);

// File: tb/sram_cycle_seq_tb.sv
module sram_cycle_seq_tb;
    localparam int AW = 24;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = 2'b11;
    logic        req_ack;
    logic [15:0] rsp_rdata;
    logic [1:0]  cfg_wait_mode = 2'b00;
    logic        cfg_bus16 = 1'b1, cfg_byte_write = 1'b0, cfg_we_timed = 1'b1;
    logic [5:0]  cfg_rd_setup = 6'd1, cfg_rd_pulse = 6'd1, cfg_rd_hold = 6'd1;
    logic [5:0]  cfg_wr_setup = 6'd1, cfg_wr_pulse = 6'd1, cfg_wr_hold = 6'd1;
    logic [AW-1:0] mem_addr;
    logic        mem_cs_n, mem_rd_n, mem_we_n, mem_dq_oe;
    logic [1:0]  mem_wr_n, mem_bs_n;
    logic [15:0] mem_dq_o;
    logic [15:0] mem_dq_i = '0;
    logic        mem_wait_n = 1'b1;

    int n_run = 0, n_fail = 0;

    typedef struct {
        logic [8:0]  pins;   // cs rd we wr[1:0] bs[1:0] oe ack
        logic [15:0] dq;
        logic [15:0] rdata;
        bit          chk_rd;
        string       tag;
    } exp_t;

    exp_t expq[$];

    always #5 clk = ~clk;

    sram_cycle_seq #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .req_ack(req_ack), .rsp_rdata(rsp_rdata), .cfg_wait_mode(cfg_wait_mode),
        .cfg_bus16(cfg_bus16), .cfg_byte_write(cfg_byte_write),
        .cfg_we_timed(cfg_we_timed), .cfg_rd_setup(cfg_rd_setup),
        .cfg_rd_pulse(cfg_rd_pulse), .cfg_rd_hold(cfg_rd_hold),
        .cfg_wr_setup(cfg_wr_setup), .cfg_wr_pulse(cfg_wr_pulse),
        .cfg_wr_hold(cfg_wr_hold), .mem_addr(mem_addr), .mem_cs_n(mem_cs_n),
        .mem_rd_n(mem_rd_n), .mem_we_n(mem_we_n), .mem_wr_n(mem_wr_n),
        .mem_bs_n(mem_bs_n), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
        .mem_dq_i(mem_dq_i), .mem_wait_n(mem_wait_n)
    );

    function automatic exp_t idle_entry(bit ack, string tag);
        exp_t e;
        e.pins   = {1'b1, 1'b1, 1'b1, 2'b11, 2'b11, 1'b0, ack};
        e.dq     = '0;
        e.rdata  = '0;
        e.chk_rd = 1'b0;
        e.tag    = tag;
        return e;
    endfunction

    // ph: 1 setup, 2 pulse, 3 hold
    function automatic exp_t bus_entry(int ph, bit wr, bit b16, bit bw, bit wct,
                                       logic [1:0] be, logic [15:0] wd, string tag);
        exp_t e;
        bit cs, rd, we, oe, strobe, cson;
        logic [1:0] wrs, bss;
        bit pulse = (ph == 2);
        cs = 1; rd = 1; we = 1; oe = 0; wrs = 2'b11;
        bss = (b16 && !bw) ? ~be : 2'b11;
        if (!wr) begin
            cs = 0; rd = !pulse;
        end else begin
            oe     = 1;
            strobe = wct ? pulse : 1'b1;
            cson   = wct ? 1'b1 : pulse;
            cs     = !cson;
            if (b16 && bw) wrs = strobe ? ~be : 2'b11;
            else           we  = !strobe;
        end
        e.pins   = {cs, rd, we, wrs, bss, oe, 1'b0};
        e.dq     = b16 ? wd : {8'h00, wd[7:0]};
        e.rdata  = '0;
        e.chk_rd = 1'b0;
        e.tag    = tag;
        return e;
    endfunction

    always @(negedge clk) begin
        exp_t e;
        logic [8:0] act;
        if (expq.size() > 0) e = expq.pop_front();
        else                 e = idle_entry(1'b0, "R1");
        act = {mem_cs_n, mem_rd_n, mem_we_n, mem_wr_n, mem_bs_n, mem_dq_oe, req_ack};
        n_run++;
        if (act !== e.pins) begin
            n_fail++;
            $display("FAIL %s pins act=%b exp=%b at %0t", e.tag, act, e.pins, $time);
        end
        if (e.pins[1] === 1'b1) begin
            n_run++;
            if (mem_dq_o !== e.dq) begin
                n_fail++;
                $display("FAIL %s dq act=%h exp=%h", e.tag, mem_dq_o, e.dq);
            end
        end
        if (e.chk_rd) begin
            n_run++;
            if (rsp_rdata !== e.rdata) begin
                n_fail++;
                $display("FAIL %s rdata act=%h exp=%h", e.tag, rsp_rdata, e.rdata);
            end
        end
    end

    // wc: design cycle (1 = first after accept) where the synchronised wait
    // first reads low; wl: number of such cycles; ext: expected pulse growth.
    task automatic run(input bit wr, input bit b16, input bit bw, input bit wct,
                       input logic [1:0] wm, input logic [1:0] be,
                       input int s, input int p, input int h, input logic [15:0] data,
                       input int wc, input int wl, input int ext, input bit scramble,
                       input string tag);
        int peff = (p == 0) ? 1 : p;
        int heff = (wm[1] && h == 0) ? 1 : h;
        exp_t e;
        @(posedge clk); #1;
        req_write = wr; req_be = be; req_wdata = data; req_addr = AW'(data);
        mem_dq_i = data;
        cfg_bus16 = b16; cfg_byte_write = bw; cfg_we_timed = wct; cfg_wait_mode = wm;
        cfg_rd_setup = 6'(s); cfg_rd_pulse = 6'(p); cfg_rd_hold = 6'(h);
        cfg_wr_setup = 6'(s); cfg_wr_pulse = 6'(p); cfg_wr_hold = 6'(h);
        req_valid = 1'b1;
        expq.push_back(idle_entry(1'b0, tag));
        for (int i = 0; i < s; i++)          expq.push_back(bus_entry(1, wr, b16, bw, wct, be, data, tag));
        for (int i = 0; i < peff + ext; i++) expq.push_back(bus_entry(2, wr, b16, bw, wct, be, data, tag));
        for (int i = 0; i < heff; i++)       expq.push_back(bus_entry(3, wr, b16, bw, wct, be, data, tag));
        e = idle_entry(1'b1, tag);
        if (!wr) begin
            e.chk_rd = 1'b1;
            e.rdata  = b16 ? data : {8'h00, data[7:0]};
        end
        expq.push_back(e);
        if (wl > 0) begin
            fork
                begin
                    repeat (wc - 2) @(posedge clk);
                    #1 mem_wait_n = 1'b0;
                    repeat (wl) @(posedge clk);
                    #1 mem_wait_n = 1'b1;
                end
            join_none
        end
        if (scramble) begin
            fork
                begin
                    @(posedge clk); #2;
                    cfg_rd_setup = 6'd9; cfg_rd_pulse = 6'd9; cfg_rd_hold = 6'd9;
                    cfg_wr_setup = 6'd9; cfg_wr_pulse = 6'd9; cfg_wr_hold = 6'd9;
                    cfg_we_timed = !wct; cfg_bus16 = !b16; cfg_wait_mode = 2'b10;
                    req_be = ~be; req_wdata = ~data; req_write = !wr;
                end
            join_none
        end
        do begin
            @(negedge clk); #1;
        end while (expq.size() != 0);
        req_valid = 1'b0;
    endtask

    initial begin
        #1_500_000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;                        // R1 idle checked every cycle of reset
        repeat (2) @(posedge clk);
        // R2 basic read, R7 byte-select read lanes
        run(0, 1, 0, 1, 2'b00, 2'b11, 2, 3, 2, 16'h5AC3, 0, 0, 0, 0, "R2");
        run(0, 1, 0, 1, 2'b00, 2'b01, 0, 2, 0, 16'h1357, 0, 0, 0, 0, "R2");
        run(0, 1, 0, 1, 2'b00, 2'b10, 1, 2, 1, 16'h2468, 0, 0, 0, 0, "R7");
        // R3 zero pulse
        run(0, 1, 0, 1, 2'b00, 2'b11, 1, 0, 1, 16'h0F0F, 0, 0, 0, 0, "R3");
        // R5 narrow read masks the upper byte
        run(0, 0, 0, 1, 2'b00, 2'b11, 1, 2, 1, 16'hA5C3, 0, 0, 0, 0, "R5");
        // R4 both write timing modes
        run(1, 1, 0, 1, 2'b00, 2'b10, 1, 2, 1, 16'hBEEF, 0, 0, 0, 0, "R4");
        run(1, 1, 0, 0, 2'b00, 2'b11, 2, 2, 2, 16'hCAFE, 0, 0, 0, 0, "R4");
        // R8 byte-write style, write and read
        run(1, 1, 1, 1, 2'b00, 2'b01, 1, 3, 1, 16'h7E81, 0, 0, 0, 0, "R8");
        run(1, 1, 1, 0, 2'b00, 2'b10, 1, 1, 1, 16'h3C3C, 0, 0, 0, 0, "R8");
        run(0, 1, 1, 1, 2'b00, 2'b01, 1, 2, 1, 16'h9966, 0, 0, 0, 0, "R8");
        // R6 narrow write
        run(1, 0, 0, 1, 2'b00, 2'b11, 1, 2, 1, 16'h1234, 0, 0, 0, 0, "R6");
        // R9 wait ignored in off and reserved modes
        run(0, 1, 0, 1, 2'b00, 2'b11, 1, 3, 1, 16'h4444, 2, 5, 0, 0, "R9");
        run(1, 1, 0, 1, 2'b01, 2'b11, 1, 3, 1, 16'h5555, 2, 5, 0, 0, "R9");
        // R10 freeze inside the pulse, read and write
        run(0, 1, 0, 1, 2'b10, 2'b11, 2, 3, 1, 16'h6789, 4, 3, 3, 0, "R10");
        run(1, 1, 0, 1, 2'b10, 2'b01, 1, 2, 2, 16'h8765, 2, 2, 2, 0, "R10");
        // R11 ready at pulse end, and early low ignored
        run(0, 1, 0, 1, 2'b11, 2'b11, 1, 3, 1, 16'hABCD, 4, 2, 2, 0, "R11");
        run(0, 1, 0, 1, 2'b11, 2'b11, 1, 3, 1, 16'hDCBA, 2, 1, 0, 0, "R11");
        // R12 hold raised to one in freeze and ready modes
        run(0, 1, 0, 1, 2'b10, 2'b11, 1, 2, 0, 16'h1111, 0, 0, 0, 0, "R12");
        run(1, 1, 0, 1, 2'b11, 2'b11, 0, 1, 0, 16'h2222, 0, 0, 0, 0, "R12");
        // R13 wait seen only in setup or only in hold
        run(0, 1, 0, 1, 2'b10, 2'b11, 4, 2, 1, 16'h3333, 2, 2, 0, 0, "R13");
        run(1, 1, 0, 1, 2'b10, 2'b11, 1, 1, 3, 16'h6666, 3, 2, 0, 0, "R13");
        // R14 inputs changed after acceptance
        run(0, 1, 0, 1, 2'b00, 2'b11, 2, 2, 2, 16'h7777, 0, 0, 0, 1, "R14");
        run(1, 1, 0, 1, 2'b00, 2'b10, 1, 3, 1, 16'h8888, 0, 0, 0, 1, "R14");
        repeat (4) @(posedge clk);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule